// File: doc/BRIEF.md
# External Memory Port Region Mapper

This block sits between three requesters (instruction fetch, X data and Y data) and two identical external bus ports, A and B. Each address space is cut into eight regions of equal size, chosen by the top three address bits. A 24-bit configuration word holds one bit per space and region, and that bit picks the port that serves the region. In each cycle the block decodes every valid request, gives each port to at most one request, and drives that port's address, write data, write enable and a three-bit space strobe.

When two or three requests in the same cycle land on one port, X data goes first, then Y data, then program. The losers see `ready` low and must hold their request until a later cycle. Read data taken from a port is registered. It comes back to the requesters one cycle later on a per-port response channel that carries a space tag.

Top module: `ext_region_mapper`

## Requirements
- R1: After reset the configuration word reads as zero. A write with `cfg_we` high replaces it at the next clock edge, and `cfg_rdata` always shows the current word.
- R2: The region is address bits [31:29]. The request of space s (program=0, X=1, Y=2) uses configuration bit s*8+region. A 0 in that bit selects port A and a 1 selects port B.
- R3: In the same cycle, a port drives the address, write data and write enable of the request it grants.
- R4: Two requests that map to different ports are both granted in the same cycle.
- R5: A port's strobe is one-hot for a granted access: bit 0 for program, bit 1 for X, bit 2 for Y.
- R6: Among requests that map to the same port, X beats Y and Y beats program. Every loser sees its `ready` low.
- R7: A port with no grant drives all strobes low and write enable low, and keeps its address at the last granted value (zero after reset).
- R8: A granted read raises that port's response valid one cycle later. The response carries the space tag (0 program, 1 X, 2 Y) and the read data the port presented in the grant cycle. A granted write produces no response.
- R9: A request that was stalled is granted in a later cycle once no higher-priority request targets its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 24 | New configuration word |
| cfg_rdata | output | 24 | Current configuration word |
| p_valid | input | 1 | Program request valid |
| p_we | input | 1 | Program request is a write |
| p_addr | input | 32 | Program request address |
| p_wdata | input | 32 | Program request write data |
| p_ready | output | 1 | Program request granted this cycle |
| x_valid | input | 1 | X data request valid |
| x_we | input | 1 | X data request is a write |
| x_addr | input | 32 | X data request address |
| x_wdata | input | 32 | X data request write data |
| x_ready | output | 1 | X data request granted this cycle |
| y_valid | input | 1 | Y data request valid |
| y_we | input | 1 | Y data request is a write |
| y_addr | input | 32 | Y data request address |
| y_wdata | input | 32 | Y data request write data |
| y_ready | output | 1 | Y data request granted this cycle |
| ea_addr | output | 32 | Port A address |
| ea_wdata | output | 32 | Port A write data |
| ea_we | output | 1 | Port A write enable |
| ea_strb | output | 3 | Port A space strobes {Y,X,P} |
| ea_rdata | input | 32 | Port A read data |
| eb_addr | output | 32 | Port B address |
| eb_wdata | output | 32 | Port B write data |
| eb_we | output | 1 | Port B write enable |
| eb_strb | output | 3 | Port B space strobes {Y,X,P} |
| eb_rdata | input | 32 | Port B read data |
| ra_vld | output | 1 | Port A read response valid |
| ra_spc | output | 2 | Port A response space tag |
| ra_data | output | 32 | Port A response data |
| rb_vld | output | 1 | Port B read response valid |
| rb_spc | output | 2 | Port B response space tag |
| rb_data | output | 32 | Port B response data |

## Verification
The hardest case to reach is a three-way conflict: all requests valid in one cycle, with the configuration bits of three different region/space pairs pointing at the same port. Random addresses and configuration words seldom line up that way. Directed cycles therefore load an all-zero or all-one word, send all three requests to one port, and then remove the winners one at a time to show that Y and then program are granted. A directed split mapping covers the dual-grant case. Random traffic with occasional configuration writes covers the rest. It also checks the one-cycle response tags and the address hold on idle ports.

// File: rtl/ext_region_mapper.sv
module ext_region_mapper #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [3*NREG-1:0]    cfg_wdata,
  output logic [3*NREG-1:0]    cfg_rdata,
  input  logic                 p_valid,
  input  logic                 p_we,
  input  logic [AW-1:0]        p_addr,
  input  logic [DW-1:0]        p_wdata,
  output logic                 p_ready,
  input  logic                 x_valid,
  input  logic                 x_we,
  input  logic [AW-1:0]        x_addr,
  input  logic [DW-1:0]        x_wdata,
  output logic                 x_ready,
  input  logic                 y_valid,
  input  logic                 y_we,
  input  logic [AW-1:0]        y_addr,
  input  logic [DW-1:0]        y_wdata,
  output logic                 y_ready,
  output logic [AW-1:0]        ea_addr,
  output logic [DW-1:0]        ea_wdata,
  output logic                 ea_we,
  output logic [2:0]           ea_strb,
  input  logic [DW-1:0]        ea_rdata,
  output logic [AW-1:0]        eb_addr,
  output logic [DW-1:0]        eb_wdata,
  output logic                 eb_we,
  output logic [2:0]           eb_strb,
  input  logic [DW-1:0]        eb_rdata,
  output logic                 ra_vld,
  output logic [1:0]           ra_spc,
  output logic [DW-1:0]        ra_data,
  output logic                 rb_vld,
  output logic [1:0]           rb_spc,
  output logic [DW-1:0]        rb_data
);
  localparam int NSP = 3;
  localparam int RB  = $clog2(NREG);
  localparam int CW  = NSP * NREG;

  logic [CW-1:0]  cfg;
  logic [NSP-1:0] vld, wen, tgt;
  logic [AW-1:0]  ad [NSP];
  logic [DW-1:0]  wd [NSP];
  logic [NSP-1:0] gnt [2];
  logic [AW-1:0]  oaddr [2];
  logic [DW-1:0]  owd [2];
  logic [1:0]     owe;
  logic [DW-1:0]  prd [2];
  logic [1:0]     rvld;
  logic [1:0]     rspc [2];
  logic [DW-1:0]  rdat [2];

  assign vld   = {y_valid, x_valid, p_valid};
  assign wen   = {y_we, x_we, p_we};
  assign ad[0] = p_addr;  assign ad[1] = x_addr;  assign ad[2] = y_addr;
  assign wd[0] = p_wdata; assign wd[1] = x_wdata; assign wd[2] = y_wdata;
  assign prd[0] = ea_rdata;
  assign prd[1] = eb_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_we) cfg <= cfg_wdata;
  end
  assign cfg_rdata = cfg;

  for (genvar s = 0; s < NSP; s++) begin : g_dec
    logic [NREG-1:0] row;
    assign row    = cfg[s*NREG +: NREG];
    assign tgt[s] = row[ad[s][AW-1 -: RB]];
  end

  for (genvar q = 0; q < 2; q++) begin : g_port
    logic [NSP-1:0] want;
    logic [AW-1:0]  hold;
    assign want   = vld & (q == 1 ? tgt : ~tgt);
    assign gnt[q] = {want[2] & ~want[1], want[1], want[0] & ~want[1] & ~want[2]};

    always_comb begin
      oaddr[q] = hold;
      owd[q]   = '0;
      owe[q]   = 1'b0;
      for (int s = 0; s < NSP; s++) begin
        if (gnt[q][s]) begin
          oaddr[q] = ad[s];
          owd[q]   = wd[s];
          owe[q]   = wen[s];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold    <= '0;
        rvld[q] <= 1'b0;
        rspc[q] <= '0;
        rdat[q] <= '0;
      end else begin
        if (|gnt[q]) hold <= oaddr[q];
        rvld[q] <= |gnt[q] & ~owe[q];
        rspc[q] <= gnt[q][1] ? 2'd1 : gnt[q][2] ? 2'd2 : 2'd0;
        rdat[q] <= prd[q];
      end
    end
  end

  assign p_ready  = gnt[0][0] | gnt[1][0];
  assign x_ready  = gnt[0][1] | gnt[1][1];
  assign y_ready  = gnt[0][2] | gnt[1][2];
  assign ea_addr  = oaddr[0];
  assign ea_wdata = owd[0];
  assign ea_we    = owe[0];
  assign ea_strb  = gnt[0];
  assign eb_addr  = oaddr[1];
  assign eb_wdata = owd[1];
  assign eb_we    = owe[1];
  assign eb_strb  = gnt[1];
  assign ra_vld   = rvld[0];
  assign ra_spc   = rspc[0];
  assign ra_data  = rdat[0];
  assign rb_vld   = rvld[1];
  assign rb_spc   = rspc[1];
  assign rb_data  = rdat[1];
endmodule

// File: rtl/ext_region_mapper_chk.sv
module ext_region_mapper_chk #(
  parameter int AW   = 32,
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3*NREG-1:0] cfg_rdata,
  input logic              p_valid,
  input logic              x_valid,
  input logic              y_valid,
  input logic [AW-1:0]     x_addr,
  input logic [AW-1:0]     y_addr,
  input logic              p_ready,
  input logic              x_ready,
  input logic              y_ready,
  input logic [AW-1:0]     ea_addr,
  input logic [AW-1:0]     eb_addr,
  input logic              ea_we,
  input logic              eb_we,
  input logic [2:0]        ea_strb,
  input logic [2:0]        eb_strb,
  input logic              ra_vld,
  input logic              rb_vld
);
  localparam int RB = $clog2(NREG);
  logic [NREG-1:0] xrow, yrow;
  logic xt, yt;
  assign xrow = cfg_rdata[NREG +: NREG];
  assign yrow = cfg_rdata[2*NREG +: NREG];
  assign xt   = xrow[x_addr[AW-1 -: RB]];
  assign yt   = yrow[y_addr[AW-1 -: RB]];

  AST_STRB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ea_strb) && $onehot0(eb_strb)); // R5
  AST_TWO_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({p_ready, x_ready, y_ready}) == $countones({ea_strb, eb_strb})); // R4
  AST_X_BEATS_Y: assert property (@(posedge clk) disable iff (!rst_n)
    (x_valid && y_valid && xt == yt) |-> (x_ready && !y_ready)); // R6
  AST_IDLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_strb == 3'b000 && $past(rst_n)) |-> (ea_addr == $past(ea_addr) && !ea_we)); // R7
  AST_IDLE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (eb_strb == 3'b000 && $past(rst_n)) |-> (eb_addr == $past(eb_addr) && !eb_we)); // R7
  AST_RSP_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_strb != 3'b000 && !ea_we) |=> ra_vld); // R8
  AST_RSP_B: assert property (@(posedge clk) disable iff (!rst_n)
    (eb_strb != 3'b000 && !eb_we) |=> rb_vld); // R8
endmodule

bind ext_region_mapper ext_region_mapper_chk #(.AW(AW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata),
  .p_valid(p_valid), .x_valid(x_valid), .y_valid(y_valid),
  .x_addr(x_addr), .y_addr(y_addr),
  .p_ready(p_ready), .x_ready(x_ready), .y_ready(y_ready),
  .ea_addr(ea_addr), .eb_addr(eb_addr), .ea_we(ea_we), .eb_we(eb_we),
  .ea_strb(ea_strb), .eb_strb(eb_strb), .ra_vld(ra_vld), .rb_vld(rb_vld)
);

// File: tb/sim_ext_region_mapper.sv
module sim_ext_region_mapper;
  localparam int PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [23:0] cfg_wdata = '0, cfg_rdata;
  logic [2:0] bv = '0, bw = '0;
  logic [31:0] ba [3];
  logic [31:0] bd [3];
  logic p_ready, x_ready, y_ready;
  logic [31:0] ea_addr, ea_wdata, ea_rdata, eb_addr, eb_wdata, eb_rdata;
  logic ea_we, eb_we, ra_vld, rb_vld;
  logic [2:0] ea_strb, eb_strb;
  logic [1:0] ra_spc, rb_spc;
  logic [31:0] ra_data, rb_data;
  int checks = 0, errs = 0;
  logic [23:0] cfg_m = '0;
  logic [31:0] hold_m [2];
  logic        erv [2];
  logic [1:0]  ers [2];
  logic [31:0] erd [2];

  always #(PER/2) clk = ~clk;
  assign ea_rdata = ea_addr ^ 32'h5A5A_0000;
  assign eb_rdata = ~eb_addr;

  ext_region_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .p_valid(bv[0]), .p_we(bw[0]), .p_addr(ba[0]), .p_wdata(bd[0]), .p_ready(p_ready),
    .x_valid(bv[1]), .x_we(bw[1]), .x_addr(ba[1]), .x_wdata(bd[1]), .x_ready(x_ready),
    .y_valid(bv[2]), .y_we(bw[2]), .y_addr(ba[2]), .y_wdata(bd[2]), .y_ready(y_ready),
    .ea_addr(ea_addr), .ea_wdata(ea_wdata), .ea_we(ea_we), .ea_strb(ea_strb), .ea_rdata(ea_rdata),
    .eb_addr(eb_addr), .eb_wdata(eb_wdata), .eb_we(eb_we), .eb_strb(eb_strb), .eb_rdata(eb_rdata),
    .ra_vld(ra_vld), .ra_spc(ra_spc), .ra_data(ra_data),
    .rb_vld(rb_vld), .rb_spc(rb_spc), .rb_data(rb_data));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit port_of(input int s, input logic [31:0] a);
    return cfg_m[s*8 + int'(a[31:29])];
  endfunction

  task automatic step(input logic [2:0] v, input logic [2:0] w,
                      input logic [31:0] a0, a1, a2, d0, d1, d2,
                      input logic cw, input logic [23:0] cd);
    logic [2:0] g [2];
    logic [2:0] rdy;
    logic [31:0] eaddr, ewd;
    logic ewe;
    logic [31:0] aa [3];
    logic [31:0] dd [3];
    aa[0] = a0; aa[1] = a1; aa[2] = a2;
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    chk(ra_vld == erv[0] && (!erv[0] || (ra_spc == ers[0] && ra_data == erd[0])), "R8 port A response",
        {ra_vld, ra_spc, ra_data}, {erv[0], ers[0], erd[0]});
    chk(rb_vld == erv[1] && (!erv[1] || (rb_spc == ers[1] && rb_data == erd[1])), "R8 port B response",
        {rb_vld, rb_spc, rb_data}, {erv[1], ers[1], erd[1]});
    bv = v; bw = w; ba = aa; bd = dd; cfg_we = cw; cfg_wdata = cd;
    #1;
    for (int q = 0; q < 2; q++) begin
      logic [2:0] want;
      for (int s = 0; s < 3; s++) want[s] = v[s] && (port_of(s, aa[s]) == q[0]);
      g[q] = 3'b000;
      if (want[1]) g[q] = 3'b010;
      else if (want[2]) g[q] = 3'b100;
      else if (want[0]) g[q] = 3'b001;
    end
    rdy = g[0] | g[1];
    chk({y_ready, x_ready, p_ready} == rdy, "R6/R4/R9 ready", {y_ready, x_ready, p_ready}, rdy);
    chk(ea_strb == g[0] && eb_strb == g[1], "R2/R5 strobes", {ea_strb, eb_strb}, {g[0], g[1]});
    for (int q = 0; q < 2; q++) begin
      int s;
      s = g[q][1] ? 1 : g[q][2] ? 2 : 0;
      eaddr = (g[q] != 0) ? aa[s] : hold_m[q];
      ewe   = (g[q] != 0) && w[s];
      ewd   = dd[s];
      if (q == 0) begin
        if (g[q] != 0) chk(ea_addr == eaddr && ea_we == ewe && ea_wdata == ewd, "R3 port A drive",
                           {ea_addr, ea_wdata}, {eaddr, ewd});
        else chk(ea_addr == eaddr && !ea_we, "R7 port A idle hold", ea_addr, eaddr);
        erd[q] = eaddr ^ 32'h5A5A_0000;
      end else begin
        if (g[q] != 0) chk(eb_addr == eaddr && eb_we == ewe && eb_wdata == ewd, "R3 port B drive",
                           {eb_addr, eb_wdata}, {eaddr, ewd});
        else chk(eb_addr == eaddr && !eb_we, "R7 port B idle hold", eb_addr, eaddr);
        erd[q] = ~eaddr;
      end
      erv[q] = (g[q] != 0) && !ewe;
      ers[q] = g[q][1] ? 2'd1 : g[q][2] ? 2'd2 : 2'd0;
      hold_m[q] = eaddr;
    end
    @(posedge clk);
    if (cw) cfg_m = cd;
    @(negedge clk);
  endtask

  initial begin
    #(PER * 150000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    process::self().srandom(32'd20240611);
    hold_m[0] = '0; hold_m[1] = '0;
    erv[0] = 1'b0; erv[1] = 1'b0; ers[0] = '0; ers[1] = '0; erd[0] = '0; erd[1] = '0;
    for (int s = 0; s < 3; s++) begin ba[s] = '0; bd[s] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_rdata == 24'h0, "R1 reset config", cfg_rdata, 0);
    chk(ea_strb == 0 && eb_strb == 0 && !ra_vld && !rb_vld, "R7 reset idle",
        {ea_strb, eb_strb, ra_vld, rb_vld}, 0);
    chk(ea_addr == 0 && eb_addr == 0, "R7 reset address", {ea_addr, eb_addr}, 0);
    // R6: three-way conflict on port A, then R9 losers granted in turn
    step(3'b111, 3'b000, 32'h2000_0010, 32'h4000_0020, 32'hE000_0030, 1, 2, 3, 0, 0);
    step(3'b101, 3'b000, 32'h2000_0010, 32'h4000_0020, 32'hE000_0030, 1, 2, 3, 0, 0);
    step(3'b001, 3'b000, 32'h2000_0010, 32'h4000_0020, 32'hE000_0030, 1, 2, 3, 0, 0);
    step(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 1'b1, 24'hFFFFFF);
    chk(cfg_rdata == 24'hFFFFFF, "R1 config write", cfg_rdata, 24'hFFFFFF);
    // R6 conflict on port B with writes
    step(3'b110, 3'b110, 32'h0000_0100, 32'hA000_0200, 32'h6000_0300, 7, 8, 9, 0, 0);
    step(3'b100, 3'b100, 32'h0000_0100, 32'hA000_0200, 32'h6000_0300, 7, 8, 9, 1'b1, 24'h010000);
    chk(cfg_rdata == 24'h010000, "R1 config write 2", cfg_rdata, 24'h010000);
    // R4: X region 0 on A, Y region 0 on B, both granted
    step(3'b110, 3'b000, 32'h0, 32'h0000_0444, 32'h0000_0888, 0, 0, 0, 0, 0);
    step(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] nc;
      nc = $urandom;
      step(3'($urandom), 3'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           ($urandom % 16) == 0, nc);
    end
    step(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule